// File: doc/BRIEF.md
# Memory-Mapped Multiply-Accumulate Unit

This block is a 16x16 hardware multiplier that sits on a simple word-wide register bus. Software writes the first operand at one of four alias addresses. The alias it picks fixes how the operands are interpreted (unsigned or two's complement) and whether the product replaces the 32-bit result or is added to it. Writing the second operand starts the operation. A fixed number of clock cycles later, the low result word, the high result word and a read-only extension word hold the outcome.

For accumulation, software first loads the start value into the two result words, which are directly writable. It then issues any number of second-operand writes. The first operand and its mode are kept between operations, so a series of products that share one factor needs only one first-operand write. The extension word depends on the mode. In unsigned modes it holds the carry out of the 32-bit addition. In signed modes it holds the sign of the 32-bit result, spread across all 16 bits. A `busy` output is high while any operation is in flight, which lets a test environment watch the latency.

Top module: `mulacc_periph`

## Requirements
- R1: After reset, every register in the window reads 0 and `busy` is 0.
- R2: The first-operand aliases are BASE+0x0 (unsigned multiply), BASE+0x2 (signed multiply), BASE+0x4 (unsigned accumulate) and BASE+0x6 (signed accumulate). Address bit 1 selects signed operation and address bit 2 selects accumulation. A read of any of the four aliases returns the stored first operand, and BASE+0x8 reads back the second operand.
- R3: Unsigned multiply loads the result words (low at BASE+0xA, high at BASE+0xC) with the unsigned product and sets the extension word (BASE+0xE) to 0.
- R4: Signed multiply loads the result words with the two's complement product. The extension word becomes 0xFFFF if the product is negative and 0 otherwise.
- R5: Unsigned accumulate adds the unsigned product to the 32-bit result modulo 2^32. The extension word becomes the carry out of that addition (0 or 1).
- R6: Signed accumulate adds the signed product to the 32-bit result modulo 2^32. The extension word becomes 0xFFFF if bit 31 of the new result is set and 0 otherwise.
- R7: Let the rising edge that captures a second-operand write be edge 0. The result and extension words keep their old values until edge 3 and show the new outcome after it. `busy` is high from edge 0 until edge 3.
- R8: The first operand and its mode are retained. Each further second-operand write reuses them without a new first-operand write.
- R9: A write to either result word loads it directly, so it can serve as the accumulator start value.
- R10: The extension word is read-only: a write to BASE+0xE changes no register.
- R11: Second-operand writes on consecutive cycles each complete in turn, three cycles after their own write. In accumulate mode both products reach the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 16 | Byte address of the register access |
| busWr | input | 1 | Write strobe, sampled on the rising edge |
| busRd | input | 1 | Read enable; read data is zero when low |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data, combinational from the address |
| busy | output | 1 | High while an operation is in flight |

## Verification
The bench builds the block with a 16-bit word, a latency of 3 and the window based at 0x130. At that size, a grid of ten boundary operands (zero, one, both extreme signed values, all-ones and a few mixed patterns) can be crossed with itself under all four modes. Each accumulate run is preloaded from the same grid, so both carry-out and negative-sum extension outcomes are covered. The short fixed latency makes it practical to check the old value at edge 2 and the new value at edge 3, and to check back-to-back operations that overlap in the pipeline.

// File: rtl/mulacc_pkg.sv
package mulacc_pkg;

  typedef struct packed {
    logic ldOp1;
    logic ldOp2;
    logic ldResLo;
    logic ldResHi;
    logic prodSigned;
    logic commit;
    logic commitSigned;
    logic commitAcc;
  } mulStrobes_t;

  typedef enum logic [2:0] {
    SEL_OP1,
    SEL_OP2,
    SEL_LO,
    SEL_HI,
    SEL_EXT,
    SEL_NONE
  } rdSel_t;

endpackage

// File: rtl/mulacc_ctrl.sv
module mulacc_ctrl
  import mulacc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE = 16'h0130,
  parameter int LAT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  output mulStrobes_t       strb,
  output rdSel_t            rdSel,
  output logic              busy
);

  logic       hit;
  logic [2:0] word;
  logic       modeSignedQ;
  logic       modeAccQ;
  logic [LAT-1:0] vldQ;
  logic [LAT-1:0] sgnQ;
  logic [LAT-1:0] accQ;

  assign hit  = (busAddr[ADDR_W-1:4] == BASE[ADDR_W-1:4]) && !busAddr[0];
  assign word = busAddr[3:1];

  always_comb begin
    strb              = '0;
    strb.ldOp1        = busWr && hit && !word[2];
    strb.ldOp2        = busWr && hit && (word == 3'd4);
    strb.ldResLo      = busWr && hit && (word == 3'd5);
    strb.ldResHi      = busWr && hit && (word == 3'd6);
    strb.prodSigned   = sgnQ[0];
    strb.commit       = vldQ[LAT-1];
    strb.commitSigned = sgnQ[LAT-1];
    strb.commitAcc    = accQ[LAT-1];
  end

  always_comb begin
    if (!hit)             rdSel = SEL_NONE;
    else if (!word[2])    rdSel = SEL_OP1;
    else if (word == 3'd4) rdSel = SEL_OP2;
    else if (word == 3'd5) rdSel = SEL_LO;
    else if (word == 3'd6) rdSel = SEL_HI;
    else                  rdSel = SEL_EXT;
  end

  // mode chosen by the alias the first operand arrives at
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeSignedQ <= 1'b0;
      modeAccQ    <= 1'b0;
    end else if (strb.ldOp1) begin
      modeSignedQ <= word[0];
      modeAccQ    <= word[1];
    end
  end

  // job tracking: one slot per cycle of latency
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vldQ[0] <= 1'b0;
      sgnQ[0] <= 1'b0;
      accQ[0] <= 1'b0;
    end else begin
      vldQ[0] <= strb.ldOp2;
      sgnQ[0] <= modeSignedQ;
      accQ[0] <= modeAccQ;
    end
  end

  for (genvar k = 1; k < LAT; k++) begin : g_track
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        vldQ[k] <= 1'b0;
        sgnQ[k] <= 1'b0;
        accQ[k] <= 1'b0;
      end else begin
        vldQ[k] <= vldQ[k-1];
        sgnQ[k] <= sgnQ[k-1];
        accQ[k] <= accQ[k-1];
      end
    end
  end

  assign busy = |vldQ;

endmodule

// File: rtl/mulacc_dpath.sv
module mulacc_dpath
  import mulacc_pkg::*;
#(
  parameter int W   = 16,
  parameter int LAT = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  mulStrobes_t strb,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] op1Q,
  output logic [W-1:0] op2Q,
  output logic [W-1:0] resLoQ,
  output logic [W-1:0] resHiQ,
  output logic [W-1:0] sumExtQ
);

  localparam int PW     = 2 * W;
  localparam int STAGES = LAT - 1;

  logic [PW-1:0] aWide, bWide, prodNext;
  logic [PW-1:0] prodPipe [STAGES];
  logic [PW-1:0] accVal;
  logic [PW:0]   sumFull;

  // sign-extend to full width when signed; low PW bits of product are exact
  assign aWide    = {{W{strb.prodSigned & op1Q[W-1]}}, op1Q};
  assign bWide    = {{W{strb.prodSigned & op2Q[W-1]}}, op2Q};
  assign prodNext = aWide * bWide;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      op1Q <= '0;
      op2Q <= '0;
    end else begin
      if (strb.ldOp1) op1Q <= wdata;
      if (strb.ldOp2) op2Q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prodPipe[0] <= '0;
    else       prodPipe[0] <= prodNext;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_prod
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) prodPipe[k] <= '0;
      else       prodPipe[k] <= prodPipe[k-1];
    end
  end

  assign accVal  = strb.commitAcc ? {resHiQ, resLoQ} : '0;
  assign sumFull = {1'b0, accVal} + {1'b0, prodPipe[STAGES-1]};

  // a completing operation takes precedence over a direct result write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resLoQ  <= '0;
      resHiQ  <= '0;
      sumExtQ <= '0;
    end else if (strb.commit) begin
      resLoQ  <= sumFull[W-1:0];
      resHiQ  <= sumFull[PW-1:W];
      sumExtQ <= strb.commitSigned ? {W{sumFull[PW-1]}} : {{(W-1){1'b0}}, sumFull[PW]};
    end else begin
      if (strb.ldResLo) resLoQ <= wdata;
      if (strb.ldResHi) resHiQ <= wdata;
    end
  end

endmodule

// File: rtl/mulacc_periph.sv
module mulacc_periph
  import mulacc_pkg::*;
#(
  parameter int W = 16,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE = 16'h0130,
  parameter int LAT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [W-1:0]      busWdata,
  output logic [W-1:0]      busRdata,
  output logic              busy
);

  mulStrobes_t strb;
  rdSel_t      rdSel;
  logic [W-1:0] op1Q, op2Q, resLoQ, resHiQ, sumExtQ;

  mulacc_ctrl #(.ADDR_W(ADDR_W), .BASE(BASE), .LAT(LAT)) uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .strb(strb), .rdSel(rdSel), .busy(busy)
  );

  mulacc_dpath #(.W(W), .LAT(LAT)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(busWdata),
    .op1Q(op1Q), .op2Q(op2Q), .resLoQ(resLoQ), .resHiQ(resHiQ), .sumExtQ(sumExtQ)
  );

  always_comb begin
    busRdata = '0;
    if (busRd) begin
      case (rdSel)
        SEL_OP1: busRdata = op1Q;
        SEL_OP2: busRdata = op2Q;
        SEL_LO:  busRdata = resLoQ;
        SEL_HI:  busRdata = resHiQ;
        SEL_EXT: busRdata = sumExtQ;
        default: busRdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/mulacc_checker.sv
module mulacc_checker
  import mulacc_pkg::*;
#(
  parameter int W   = 16,
  parameter int LAT = 3
) (
  input logic        clk,
  input logic        rstN,
  input mulStrobes_t strb,
  input logic        busy,
  input logic [W-1:0] op1Q,
  input logic [W-1:0] resLoQ,
  input logic [W-1:0] sumExtQ
);

  logic [LAT-1:0] startHist;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) startHist <= '0;
    else       startHist <= {startHist[LAT-2:0], strb.ldOp2};
  end

  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    strb.ldOp2 |=> busy); // R7

  AST_COMMIT_AFTER_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> startHist[LAT-1]); // R7

  AST_OP1_RETAINED: assert property (@(posedge clk) disable iff (!rstN)
    !strb.ldOp1 |=> $stable(op1Q)); // R8

  AST_LO_ONLY_BY_WRITE_OR_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.commit || strb.ldResLo) |=> $stable(resLoQ)); // R9

  AST_EXT_READ_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(sumExtQ)); // R10

  AST_EXT_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    (sumExtQ == '0) || (sumExtQ == W'(1)) || (sumExtQ == '1)); // R5

endmodule

bind mulacc_periph mulacc_checker #(.W(W), .LAT(LAT)) uChk (
  .clk(clk), .rstN(rstN), .strb(strb), .busy(busy),
  .op1Q(op1Q), .resLoQ(resLoQ), .sumExtQ(sumExtQ)
);

// File: tb/sim_mulacc_periph.sv
`timescale 1ns/1ps
module sim_mulacc_periph;

  localparam logic [15:0] BASE = 16'h0130;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        busy;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  mulacc_periph #(.W(16), .ADDR_W(16), .BASE(BASE), .LAT(3)) u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .busy(busy)
  );

  logic [15:0] vals [10] = '{16'h0000, 16'h0001, 16'h0002, 16'h7FFF, 16'h8000,
                             16'h8001, 16'hFFFF, 16'h1234, 16'hABCD, 16'h00FF};

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // call at a falling edge; returns at the next falling edge
  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] d);
    busAddr = a; busRd = 1'b1;
    #1 d = busRdata;
    busRd = 1'b0;
  endtask

  task automatic rdChk(input string tag, input logic [15:0] a, input logic [15:0] exp);
    logic [15:0] d;
    rd(a, d);
    chk(tag, {16'h0, d}, {16'h0, exp});
  endtask

  function automatic void model(input int mode, input logic [15:0] a, input logic [15:0] b,
                                input logic [31:0] pre, output logic [31:0] res,
                                output logic [15:0] ext);
    bit sg = mode[0];
    bit ac = mode[1];
    longint sa, sb, p;
    logic [32:0] s;
    sa = sg ? longint'($signed(a)) : longint'({48'h0, a});
    sb = sg ? longint'($signed(b)) : longint'({48'h0, b});
    p  = sa * sb;
    s  = (ac ? {1'b0, pre} : 33'h0) + {1'b0, p[31:0]};
    res = s[31:0];
    ext = sg ? {16{s[31]}} : {15'h0, s[32]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] res;
    logic [15:0] ext;
    string tags [4] = '{"R3", "R4", "R5", "R6"};

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int k = 0; k < 8; k++) rdChk("R1 reset read", BASE + 16'(2 * k), 16'h0);
    chk("R1 busy", {31'h0, busy}, 32'h0);

    // R2: aliases read back operand 1, operand 2 readback
    wr(BASE + 16'h6, 16'h1357);
    for (int k = 0; k < 4; k++) rdChk("R2 alias read", BASE + 16'(2 * k), 16'h1357);
    wr(BASE + 16'h8, 16'h2468);
    rdChk("R2 op2 read", BASE + 16'h8, 16'h2468);
    repeat (4) @(negedge clk);

    // R9: direct result writes
    wr(BASE + 16'hA, 16'hBEEF);
    wr(BASE + 16'hC, 16'hCAFE);
    rdChk("R9 lo write", BASE + 16'hA, 16'hBEEF);
    rdChk("R9 hi write", BASE + 16'hC, 16'hCAFE);

    // R7: latency and busy window
    wr(BASE + 16'hA, 16'h0000);
    wr(BASE + 16'hC, 16'h0000);
    wr(BASE + 16'h0, 16'd3);
    wr(BASE + 16'h8, 16'd5);                // edge 0 passed
    chk("R7 busy after edge0", {31'h0, busy}, 32'h1);
    rdChk("R7 old after edge0", BASE + 16'hA, 16'h0);
    @(negedge clk);                          // after edge 1
    rdChk("R7 old after edge1", BASE + 16'hA, 16'h0);
    @(negedge clk);                          // after edge 2
    rdChk("R7 old after edge2", BASE + 16'hA, 16'h0);
    chk("R7 busy after edge2", {31'h0, busy}, 32'h1);
    @(negedge clk);                          // after edge 3
    rdChk("R7 new after edge3", BASE + 16'hA, 16'd15);
    chk("R7 busy cleared", {31'h0, busy}, 32'h0);

    // R8: operand retained across operations (signed multiply)
    wr(BASE + 16'h2, 16'h8000);
    wr(BASE + 16'h8, 16'd2);
    repeat (3) @(negedge clk);
    rdChk("R8 first lo", BASE + 16'hA, 16'h0000);
    rdChk("R8 first hi", BASE + 16'hC, 16'hFFFF);
    wr(BASE + 16'h8, 16'd3);
    repeat (3) @(negedge clk);
    rdChk("R8 reuse lo", BASE + 16'hA, 16'h8000);
    rdChk("R8 reuse hi", BASE + 16'hC, 16'hFFFE);
    rdChk("R8 reuse ext", BASE + 16'hE, 16'hFFFF);

    // R10: extension word ignores writes
    wr(BASE + 16'hE, 16'h0000);
    rdChk("R10 ext unchanged", BASE + 16'hE, 16'hFFFF);
    rdChk("R10 lo unchanged", BASE + 16'hA, 16'h8000);
    rdChk("R10 hi unchanged", BASE + 16'hC, 16'hFFFE);

    // R11: back-to-back signed accumulate, 100 - 2*7 - 2*9
    wr(BASE + 16'hA, 16'd100);
    wr(BASE + 16'hC, 16'd0);
    wr(BASE + 16'h6, 16'hFFFE);
    wr(BASE + 16'h8, 16'd7);
    wr(BASE + 16'h8, 16'd9);
    repeat (2) @(negedge clk);               // after edge 3 of first
    rdChk("R11 first done", BASE + 16'hA, 16'd86);
    @(negedge clk);
    rdChk("R11 both done lo", BASE + 16'hA, 16'd68);
    rdChk("R11 both done hi", BASE + 16'hC, 16'd0);
    rdChk("R11 both done ext", BASE + 16'hE, 16'd0);

    // R3..R6: sweep of boundary operands under every mode
    for (int m = 0; m < 4; m++) begin
      for (int i = 0; i < 10; i++) begin
        for (int j = 0; j < 10; j++) begin
          logic [31:0] pre;
          pre = {vals[j], vals[i]};
          wr(BASE + 16'hA, pre[15:0]);
          wr(BASE + 16'hC, pre[31:16]);
          wr(BASE + 16'(2 * m), vals[i]);
          wr(BASE + 16'h8, vals[j]);
          repeat (3) @(negedge clk);
          model(m, vals[i], vals[j], pre, res, ext);
          rdChk({tags[m], " lo"}, BASE + 16'hA, res[15:0]);
          rdChk({tags[m], " hi"}, BASE + 16'hC, res[31:16]);
          rdChk({tags[m], " ext"}, BASE + 16'hE, ext);
        end
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule